// File: doc/BRIEF.md
# Buck Converter Fault Latch and Protection Sequencer

This block is the digital protection core of a synchronous buck controller. Analog comparators around the power stage report their decisions as single-bit inputs: current limit reached, output over-voltage, output under-voltage, switch node still high after the low-side switch turned on, and the output rising while the feedback node stays near ground. The block filters each of these in time, counted either in system clocks or in switching cycles. Switching-cycle boundaries arrive as a one-clock strobe, `cyc_start`.

Over-current is handled in two steps. The first detection suppresses high-side pulses for a fixed number of switching cycles. A second detection inside a following watch window is treated as a hard fault. Every hard fault sets a single latch and records the type that set it first. The latch turns on the output discharge resistor and runs a two-state hysteretic loop on the low-side drive: force it high until the output is below 0.5 V, release it until the output is above 0.8 V, and repeat. Only pulling `en` low or applying reset clears the latch.

The over-current FSM has three states. `OC_IDLE` moves to `OC_SKIP` on a strobe that sees the limit. `OC_SKIP` moves to `OC_WATCH` on the ninth strobe after the trigger, or trips if the limit is seen on that strobe. `OC_WATCH` trips on any strobe that sees the limit, and returns to `OC_IDLE` after the sixteenth strobe. The high-side sample FSM has two states. `HS_IDLE` moves to `HS_WAIT` on `ldrv_rise`, and `HS_WAIT` samples `sw_hi` and returns to `HS_IDLE`. The latch FSM has three states. `FL_RUN` moves to `FL_DRAIN` on any trip. `FL_DRAIN` moves to `FL_REST` when `vout_lo_0v5` is seen. `FL_REST` moves back to `FL_DRAIN` when `vout_hi_0v8` is seen. From any state, `en` low returns the latch FSM to `FL_RUN`.

Top module: `buck_fault_guard`

## Requirements
- R1: A strobe with `ilim_det` high while no over-current sequence is active sets `hdrv_inhibit` from the next clock. It stays high through the trigger cycle and the 8 switching cycles after it, and drops on the clock after the 9th following strobe.
- R2: `ilim_det` on strobes 1 to 8 after the trigger is ignored. `ilim_det` on any strobe from 9 to 16 after the trigger sets the latch with cause 1.
- R3: If `ilim_det` is absent on strobes 9 to 16, no fault results. A later detection starts a fresh skip sequence.
- R4: The latch sets with cause 2 only when `ov_cmp` is high on 16 consecutive strobes with no clock in between where it is low.
- R5: The latch sets with cause 3 when `uv_cmp` is high for `UV_CLKS` consecutive clocks while `ss_uv_mask` is low. `uv_cmp` has no effect while `ss_uv_mask` is high.
- R6: The latch sets with cause 4 when `sw_hi` is high at the clock edge exactly `HS_DLY` clocks after the edge that sampled `ldrv_rise`. `sw_hi` at any other time has no effect.
- R7: The latch sets with cause 5 when `ss_active`, `vout_hi_1v` and `fb_lo_100mv` are all high for more than `FBS_CLKS` consecutive clocks.
- R8: While latched, `ldrv_out` is forced high until `vout_lo_0v5` is seen. It is then held low until `vout_hi_0v8` is seen, and this cycle repeats. While not latched, `ldrv_out` follows `ldrv_pwm`.
- R9: `discharge_en` is high exactly when `en` is low or the latch is set.
- R10: Once set, the latch and `hdrv_inhibit` stay high while `en` stays high. Driving `en` low clears the latch and sets the cause to 0. Reset leaves the latch clear with cause 0.
- R11: `fault_cause` keeps the code of the first fault that set the latch (1 over-current, 2 over-voltage, 3 under-voltage, 4 high-side, 5 feedback short) and ignores faults that arrive later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| en | input | 1 | Enable; low clears the latch |
| cyc_start | input | 1 | One-clock strobe at each switching-cycle start |
| ilim_det | input | 1 | Current limit detect |
| ov_cmp | input | 1 | Feedback above over-voltage threshold |
| uv_cmp | input | 1 | Feedback below under-voltage threshold |
| ss_uv_mask | input | 1 | Soft-start still below under-voltage enable level |
| ss_active | input | 1 | Soft-start in progress |
| ldrv_rise | input | 1 | One-clock pulse when low-side drive rises |
| sw_hi | input | 1 | Switch node above 0.5 V |
| vout_hi_1v | input | 1 | Output above 1 V |
| fb_lo_100mv | input | 1 | Feedback below 100 mV |
| vout_lo_0v5 | input | 1 | Output below 0.5 V |
| vout_hi_0v8 | input | 1 | Output above 0.8 V |
| ldrv_pwm | input | 1 | Low-side drive request from the modulator |
| hdrv_inhibit | output | 1 | Suppress high-side drive |
| ldrv_out | output | 1 | Final low-side drive |
| discharge_en | output | 1 | Output discharge resistor enable |
| fault_latched | output | 1 | Fault latch state |
| fault_cause | output | 3 | Code of the first fault |

## Verification
The bench places a second current-limit detection on every strobe from 1 to 20 after a trigger. Only distances 9 to 16 may latch. An off-by-one in the skip or watch counters shifts or shrinks that window, and also moves the strobe where `hdrv_inhibit` drops. The time filters are swept across their thresholds, one clock or strobe below and above. A filter that does not restart when its condition breaks, or that trips one count early, shows up there. The high-side sample is tested with `sw_hi` high exactly at the sample edge and one clock early. The discharge loop, the first-cause capture and clearing by `en` are each checked after a latched fault.

// File: rtl/buck_fault_pkg.sv
package buck_fault_pkg;
    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_OC   = 3'd1,
        CAUSE_OV   = 3'd2,
        CAUSE_UV   = 3'd3,
        CAUSE_HS   = 3'd4,
        CAUSE_FBS  = 3'd5
    } fault_cause_e;

    localparam int TRIP_N   = 5;
    localparam int TRIP_OC  = 0;
    localparam int TRIP_OV  = 1;
    localparam int TRIP_UV  = 2;
    localparam int TRIP_HS  = 3;
    localparam int TRIP_FBS = 4;

    function automatic fault_cause_e trip_to_cause(input int idx);
        case (idx)
            TRIP_OC:  return CAUSE_OC;
            TRIP_OV:  return CAUSE_OV;
            TRIP_UV:  return CAUSE_UV;
            TRIP_HS:  return CAUSE_HS;
            default:  return CAUSE_FBS;
        endcase
    endfunction
endpackage

// File: rtl/oc_skip_fsm.sv
module oc_skip_fsm #(
    parameter int SKIP_CYC  = 8,
    parameter int WATCH_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cyc_start,
    input  logic ilim_det,
    output logic inhibit,
    output logic trip
);
    localparam int LAST = SKIP_CYC + WATCH_CYC;
    localparam int CW   = $clog2(LAST + 1);
    localparam logic [CW-1:0] SKIP_END = CW'(SKIP_CYC + 1);
    localparam logic [CW-1:0] LAST_C   = CW'(LAST);

    typedef enum logic [1:0] {OC_IDLE, OC_SKIP, OC_WATCH} oc_state_e;

    oc_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          trip_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OC_IDLE;
            cnt_q   <= '0;
            trip    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            trip    <= trip_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        trip_d  = 1'b0;
        if (clr) begin
            state_d = OC_IDLE;
            cnt_d   = '0;
        end else if (cyc_start) begin
            unique case (state_q)
                OC_IDLE: begin
                    if (ilim_det) begin
                        state_d = OC_SKIP;
                        cnt_d   = '0;
                    end
                end
                OC_SKIP: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_d == SKIP_END) begin
                        if (ilim_det) begin
                            trip_d  = 1'b1;
                            state_d = OC_IDLE;
                        end else begin
                            state_d = OC_WATCH;
                        end
                    end
                end
                OC_WATCH: begin
                    cnt_d = cnt_q + 1'b1;
                    if (ilim_det) begin
                        trip_d  = 1'b1;
                        state_d = OC_IDLE;
                    end else if (cnt_d == LAST_C) begin
                        state_d = OC_IDLE;
                    end
                end
                default: state_d = OC_IDLE;
            endcase
        end
    end

    always_comb inhibit = (state_q == OC_SKIP);

    AST_SKIP_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inhibit) |-> $past(cyc_start && ilim_det)); // R1
    AST_OC_TRIP_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> $past(state_q != OC_IDLE && ilim_det && cyc_start)); // R2
endmodule

// File: rtl/hold_filter.sv
module hold_filter #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic cond,
    output logic trip
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] TOP = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            trip  <= 1'b0;
        end else begin
            trip <= !clr && cond && tick && (cnt_q == TOP);
            if (clr || !cond)
                cnt_q <= '0;
            else if (tick && cnt_q != TOP)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_FILT_COND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> $past(cond)); // R4
endmodule

// File: rtl/hs_sampler.sv
module hs_sampler #(
    parameter int HS_DLY = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ldrv_rise,
    input  logic sw_hi,
    output logic trip
);
    localparam int CW = $clog2(HS_DLY + 1);
    localparam logic [CW-1:0] LASTC = CW'(HS_DLY - 1);

    typedef enum logic {HS_IDLE, HS_WAIT} hs_state_e;

    hs_state_e     state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
            trip    <= 1'b0;
        end else if (clr) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
            trip    <= 1'b0;
        end else begin
            trip <= 1'b0;
            unique case (state_q)
                HS_IDLE: begin
                    if (ldrv_rise) begin
                        state_q <= HS_WAIT;
                        cnt_q   <= '0;
                    end
                end
                HS_WAIT: begin
                    if (cnt_q == LASTC) begin
                        trip    <= sw_hi;
                        state_q <= HS_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    AST_HS_SAMPLE_ONLY_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> $past(state_q == HS_WAIT && sw_hi)); // R6
endmodule

// File: rtl/fault_latch_ctl.sv
module fault_latch_ctl
    import buck_fault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TRIP_N-1:0] trips,
    input  logic              vout_lo_0v5,
    input  logic              vout_hi_0v8,
    input  logic              ldrv_pwm,
    output logic              latched,
    output logic              ldrv_out,
    output fault_cause_e      cause
);
    typedef enum logic [1:0] {FL_RUN, FL_DRAIN, FL_REST} fl_state_e;

    fl_state_e    state_q;
    fault_cause_e first_d;

    always_comb begin
        first_d = CAUSE_NONE;
        for (int i = TRIP_N - 1; i >= 0; i--)
            if (trips[i]) first_d = trip_to_cause(i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_RUN;
            cause   <= CAUSE_NONE;
        end else if (!en) begin
            state_q <= FL_RUN;
            cause   <= CAUSE_NONE;
        end else begin
            unique case (state_q)
                FL_RUN: begin
                    if (|trips) begin
                        state_q <= FL_DRAIN;
                        cause   <= first_d;
                    end
                end
                FL_DRAIN: if (vout_lo_0v5) state_q <= FL_REST;
                FL_REST:  if (vout_hi_0v8) state_q <= FL_DRAIN;
                default:  state_q <= FL_RUN;
            endcase
        end
    end

    always_comb begin
        latched  = 1'b0;
        ldrv_out = ldrv_pwm;
        unique case (state_q)
            FL_RUN:   begin latched = 1'b0; ldrv_out = ldrv_pwm; end
            FL_DRAIN: begin latched = 1'b1; ldrv_out = 1'b1;     end
            FL_REST:  begin latched = 1'b1; ldrv_out = 1'b0;     end
            default:  begin latched = 1'b0; ldrv_out = ldrv_pwm; end
        endcase
    end

    AST_DRAIN_TO_REST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) && $past(state_q == FL_DRAIN) && $past(vout_lo_0v5) |-> !ldrv_out); // R8
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && $past(latched) |-> latched); // R10
    AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && $past(latched) |-> $stable(cause)); // R11
    AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !latched && cause == CAUSE_NONE); // R10
endmodule

// File: rtl/buck_fault_guard.sv
module buck_fault_guard
    import buck_fault_pkg::*;
#(
    parameter int SKIP_CYC  = 8,
    parameter int WATCH_CYC = 8,
    parameter int OV_CYC    = 16,
    parameter int UV_CLKS   = 500,
    parameter int FBS_CLKS  = 3500,
    parameter int HS_DLY    = 88
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cyc_start,
    input  logic       ilim_det,
    input  logic       ov_cmp,
    input  logic       uv_cmp,
    input  logic       ss_uv_mask,
    input  logic       ss_active,
    input  logic       ldrv_rise,
    input  logic       sw_hi,
    input  logic       vout_hi_1v,
    input  logic       fb_lo_100mv,
    input  logic       vout_lo_0v5,
    input  logic       vout_hi_0v8,
    input  logic       ldrv_pwm,
    output logic       hdrv_inhibit,
    output logic       ldrv_out,
    output logic       discharge_en,
    output logic       fault_latched,
    output logic [2:0] fault_cause
);
    logic              clr;
    logic [TRIP_N-1:0] trips;
    logic              skip;
    fault_cause_e      cause_e;

    always_comb clr = !en;

    oc_skip_fsm #(.SKIP_CYC(SKIP_CYC), .WATCH_CYC(WATCH_CYC)) u_oc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cyc_start(cyc_start),
        .ilim_det(ilim_det), .inhibit(skip), .trip(trips[TRIP_OC]));

    hold_filter #(.LEN(OV_CYC)) u_ov (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(cyc_start),
        .cond(ov_cmp), .trip(trips[TRIP_OV]));

    hold_filter #(.LEN(UV_CLKS)) u_uv (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(1'b1),
        .cond(uv_cmp && !ss_uv_mask), .trip(trips[TRIP_UV]));

    hs_sampler #(.HS_DLY(HS_DLY)) u_hs (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ldrv_rise(ldrv_rise),
        .sw_hi(sw_hi), .trip(trips[TRIP_HS]));

    hold_filter #(.LEN(FBS_CLKS + 1)) u_fbs (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(1'b1),
        .cond(ss_active && vout_hi_1v && fb_lo_100mv), .trip(trips[TRIP_FBS]));

    fault_latch_ctl u_latch (
        .clk(clk), .rst_n(rst_n), .en(en), .trips(trips),
        .vout_lo_0v5(vout_lo_0v5), .vout_hi_0v8(vout_hi_0v8),
        .ldrv_pwm(ldrv_pwm), .latched(fault_latched),
        .ldrv_out(ldrv_out), .cause(cause_e));

    always_comb begin
        fault_cause  = cause_e;
        hdrv_inhibit = skip || fault_latched;
        discharge_en = !en || fault_latched;
    end

    AST_INHIBIT_WHEN_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) && en && $past(fault_latched) |-> hdrv_inhibit); // R10
    AST_DISCHARGE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_latched) |-> discharge_en && ldrv_out); // R9
endmodule

// File: tb/buck_fault_guard_test.sv
module buck_fault_guard_test;
    localparam int UVN = 10;
    localparam int FBN = 14;
    localparam int HSD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, cyc_start = 1'b0, ilim_det = 1'b0, ov_cmp = 1'b0;
    logic uv_cmp = 1'b0, ss_uv_mask = 1'b0, ss_active = 1'b0, ldrv_rise = 1'b0;
    logic sw_hi = 1'b0, vout_hi_1v = 1'b0, fb_lo_100mv = 1'b0;
    logic vout_lo_0v5 = 1'b0, vout_hi_0v8 = 1'b0, ldrv_pwm = 1'b0;
    logic hdrv_inhibit, ldrv_out, discharge_en, fault_latched;
    logic [2:0] fault_cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    buck_fault_guard #(.UV_CLKS(UVN), .FBS_CLKS(FBN), .HS_DLY(HSD)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start),
        .ilim_det(ilim_det), .ov_cmp(ov_cmp), .uv_cmp(uv_cmp),
        .ss_uv_mask(ss_uv_mask), .ss_active(ss_active), .ldrv_rise(ldrv_rise),
        .sw_hi(sw_hi), .vout_hi_1v(vout_hi_1v), .fb_lo_100mv(fb_lo_100mv),
        .vout_lo_0v5(vout_lo_0v5), .vout_hi_0v8(vout_hi_0v8),
        .ldrv_pwm(ldrv_pwm), .hdrv_inhibit(hdrv_inhibit), .ldrv_out(ldrv_out),
        .discharge_en(discharge_en), .fault_latched(fault_latched),
        .fault_cause(fault_cause));

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic lim);
        @(negedge clk);
        cyc_start = 1'b1;
        ilim_det  = lim;
        @(negedge clk);
        cyc_start = 1'b0;
        ilim_det  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic toggle_en();
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic expect_fault(input logic f, input int c, input string tag);
        repeat (3) @(negedge clk);
        chk(fault_latched, f, tag);
        chk(fault_cause, f ? c : 0, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fault_latched, 0, "R10 reset latch");
        chk(fault_cause, 0, "R10 reset cause");
        chk(hdrv_inhibit, 0, "R1 reset inhibit");
        chk(discharge_en, 1, "R9 en low discharge");
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk(discharge_en, 0, "R9 running no discharge");
        ldrv_pwm = 1'b1;
        @(negedge clk);
        chk(ldrv_out, 1, "R8 pass-through high");
        ldrv_pwm = 1'b0;
        @(negedge clk);
        chk(ldrv_out, 0, "R8 pass-through low");

        // over-current: second detection at distance k
        for (int k = 1; k <= 20; k++) begin
            strobe(1'b1);
            chk(hdrv_inhibit, 1, "R1 inhibit after trigger");
            for (int j = 1; j < k; j++) begin
                strobe(1'b0);
                chk(hdrv_inhibit, (j <= 8) ? 1 : 0, "R1 inhibit span");
            end
            strobe(1'b1);
            for (int j = 0; j < 10; j++) strobe(1'b0);
            expect_fault((k >= 9 && k <= 16), 1, (k >= 9 && k <= 16) ? "R2 late limit" : "R3 no fault");
            if (k > 16) chk(hdrv_inhibit, 0, "R3 normal after retrigger");
            toggle_en();
        end

        // over-voltage: n consecutive strobes
        for (int n = 14; n <= 18; n++) begin
            ov_cmp = 1'b1;
            for (int j = 0; j < n; j++) strobe(1'b0);
            ov_cmp = 1'b0;
            expect_fault(n >= 16, 2, "R4 ov filter");
            toggle_en();
        end
        ov_cmp = 1'b1;
        for (int j = 0; j < 10; j++) strobe(1'b0);
        ov_cmp = 1'b0;
        @(negedge clk);
        ov_cmp = 1'b1;
        for (int j = 0; j < 10; j++) strobe(1'b0);
        ov_cmp = 1'b0;
        expect_fault(1'b0, 2, "R4 ov break restarts");
        toggle_en();

        // under-voltage
        for (int n = UVN - 2; n <= UVN + 2; n++) begin
            uv_cmp = 1'b1;
            repeat (n) @(negedge clk);
            uv_cmp = 1'b0;
            expect_fault(n >= UVN, 3, "R5 uv filter");
            toggle_en();
        end
        ss_uv_mask = 1'b1;
        uv_cmp = 1'b1;
        repeat (3 * UVN) @(negedge clk);
        uv_cmp = 1'b0;
        ss_uv_mask = 1'b0;
        expect_fault(1'b0, 3, "R5 uv masked");
        toggle_en();

        // high-side sample
        for (int early = 0; early <= 1; early++) begin
            ldrv_rise = 1'b1;
            @(negedge clk);
            ldrv_rise = 1'b0;
            repeat (HSD - 1 - early) @(negedge clk);
            sw_hi = 1'b1;
            @(negedge clk);
            sw_hi = 1'b0;
            expect_fault(early == 0, 4, early == 0 ? "R6 hs sample hit" : "R6 hs early ignored");
            toggle_en();
        end

        // feedback short during soft-start
        for (int n = FBN - 1; n <= FBN + 2; n++) begin
            ss_active = 1'b1; vout_hi_1v = 1'b1; fb_lo_100mv = 1'b1;
            repeat (n) @(negedge clk);
            fb_lo_100mv = 1'b0;
            expect_fault(n > FBN, 5, "R7 fb short filter");
            toggle_en();
        end
        fb_lo_100mv = 1'b1; ss_active = 1'b0;
        repeat (3 * FBN) @(negedge clk);
        fb_lo_100mv = 1'b0; vout_hi_1v = 1'b0;
        expect_fault(1'b0, 5, "R7 no soft-start no fault");

        // latched behaviour: first cause, hysteresis, discharge, hold
        uv_cmp = 1'b1;
        repeat (UVN + 1) @(negedge clk);
        uv_cmp = 1'b0;
        expect_fault(1'b1, 3, "R11 first cause uv");
        chk(discharge_en, 1, "R9 discharge when latched");
        chk(hdrv_inhibit, 1, "R10 inhibit when latched");
        chk(ldrv_out, 1, "R8 forced high");
        ov_cmp = 1'b1;
        for (int j = 0; j < 18; j++) strobe(1'b0);
        ov_cmp = 1'b0;
        chk(fault_cause, 3, "R11 later ov ignored");
        vout_lo_0v5 = 1'b1;
        repeat (2) @(negedge clk);
        chk(ldrv_out, 0, "R8 released below 0.5");
        vout_lo_0v5 = 1'b0;
        repeat (3) @(negedge clk);
        chk(ldrv_out, 0, "R8 held low");
        vout_hi_0v8 = 1'b1;
        repeat (2) @(negedge clk);
        chk(ldrv_out, 1, "R8 forced again above 0.8");
        vout_hi_0v8 = 1'b0;
        repeat (20) @(negedge clk);
        chk(fault_latched, 1, "R10 latch holds");
        toggle_en();
        chk(fault_latched, 0, "R10 en toggle clears");
        chk(fault_cause, 0, "R10 cause cleared");
        chk(discharge_en, 0, "R9 discharge off after clear");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule